// File: doc/BRIEF.md
# Startup Calibration Sequencer

This block orders the start-up of a current-sense calibration for a switching power converter. After every power-on reset it first runs a bandwidth tuning phase. In that phase it requests an external tuning search and waits for it to finish. It then runs a gain calibration phase, in which its own gain code sweeps upward from zero. The sweep stops at the first calibration tick on which an external comparator reports that the sensed output has reached its target. Only after both phases finish does the block allow the converter to run.

While tuning and calibration run, the block holds the test-current switches on and the converter off. During calibration it drives two non-overlapping chopper phases that swap the filter input polarity, so that an offset averages out. After calibration the tuning and gain codes are frozen and used unchanged in normal operation.

The calibration tick is derived from a slow-clock strobe divided by `DIV`. A failed tuning search, or a gain sweep that reaches full scale without a comparator trip, parks the block in a fault state with the converter disabled.

Top module: `startup_cal_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `phase_o` is 00 and `conv_en_o`, `test_sw_en_o` and `tune_req_o` are low. The next clock enters tuning.
- R2: In tuning, `phase_o` is 01, `tune_req_o` and `test_sw_en_o` are high, `conv_en_o` is low, and `gain_code_o` is 0.
- R3: A clock with `tune_done_i` high and `tune_err_i` low captures `tune_code_i` into `tune_code_o` and enters calibration (`phase_o` 10). `tune_code_o` then stays unchanged until the next reset.
- R4: In calibration, `gain_code_o` starts at 0 and rises by exactly one on each calibration tick. A calibration tick is every `DIV`-th cycle in which `slow_tick_i` is high, counted from entry into calibration. The gain code never wraps.
- R5: At a calibration tick with `cmp_hit_i` high, the gain code stops and the block enters normal operation. In normal operation `phase_o` is 11, `conv_en_o` is high, `test_sw_en_o` is low, and both codes stay fixed until reset.
- R6: `chop_p1_o` and `chop_p2_o` are high only in calibration and never together. Calibration begins with `chop_p1_o` high. The phases swap at each calibration tick, with exactly one cycle in which both are low.
- R7: A calibration tick with the gain code at its maximum and `cmp_hit_i` low sets `cal_err_o`. The block then holds `phase_o` at 00 and `conv_en_o` and `test_sw_en_o` low until reset.
- R8: A clock with `tune_done_i` and `tune_err_i` both high sets `tune_fault_o`, leaves `tune_code_o` unloaded, and holds `phase_o` at 00 with `conv_en_o`, `test_sw_en_o` and `tune_req_o` low until reset.
- R9: Each reset clears both fault flags and repeats the whole tune-then-calibrate sequence.
- R10: `cmp_hit_i` is ignored in calibration cycles that are not calibration ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| slow_tick_i | input | 1 | One-cycle slow-clock strobe |
| tune_done_i | input | 1 | Tuning search finished |
| tune_err_i | input | 1 | Tuning search failed (qualified by done) |
| tune_code_i | input | TUNE_W | Code found by the tuning search |
| cmp_hit_i | input | 1 | Comparator: sensed output reached target |
| tune_req_o | output | 1 | Request to run the tuning search |
| test_sw_en_o | output | 1 | Test-current switches on |
| conv_en_o | output | 1 | Converter enable |
| chop_p1_o | output | 1 | Chopper phase 1 |
| chop_p2_o | output | 1 | Chopper phase 2 |
| gain_code_o | output | GAIN_W | Gain code |
| tune_code_o | output | TUNE_W | Stored tuning code |
| phase_o | output | 2 | 00 reset/fault, 01 tune, 10 calibrate, 11 normal |
| tune_fault_o | output | 1 | Tuning search reported an error |
| cal_err_o | output | 1 | Gain sweep reached maximum without a trip |

## Verification
The bench sweeps the comparator trip point across every gain code of a 4-bit configuration and also runs the case with no trip at all. It counts slow ticks to confirm that the sweep stops at exactly the trip code. A divider that is off by one, or a counter that wraps at full scale instead of faulting, shows up as a wrong tick count or a wrong final code.

Between ticks the bench pulses the comparator high. A design that samples the comparator on every cycle would stop early. The bench samples the chopper outputs both in the dead cycle and in the following cycle, so an overlap or a missing gap is caught.

A tuning error, the tuning input changing after capture, and repeated resets check that codes and flags are stored once and cleared only by reset.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [2:0] {
    ST_RST, ST_TUNE, ST_CAL, ST_RUN, ST_TFAIL, ST_CFAIL
  } seq_st_e;

  localparam logic [1:0] PH_IDLE = 2'b00;
  localparam logic [1:0] PH_TUNE = 2'b01;
  localparam logic [1:0] PH_CAL  = 2'b10;
  localparam logic [1:0] PH_RUN  = 2'b11;
endpackage

// File: rtl/cal_tick_div.sv
module cal_tick_div #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic slow_tick_i,
  output logic cal_tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last       = (cnt_q == CW'(DIV - 1));
  assign cal_tick_o = en_i & slow_tick_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (slow_tick_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  // R4
  tick_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_tick_o |-> (slow_tick_i && en_i));
endmodule

// File: rtl/gain_sweep.sv
module gain_sweep #(
  parameter int GAIN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [GAIN_W-1:0] code_o,
  output logic              at_max_o
);
  logic [GAIN_W-1:0] code_q;

  assign code_o   = code_q;
  assign at_max_o = &code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= '0;
    else if (clr_i)  code_q <= '0;
    else if (step_i) code_q <= code_q + 1'b1;
  end

  // R4
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == '0 && $past(at_max_o)) |-> $past(clr_i));
endmodule

// File: rtl/chop_phase_gen.sv
module chop_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic flip_i,
  output logic p1_o,
  output logic p2_o
);
  logic sel_q, dead_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      dead_q <= 1'b0;
    end else if (!en_i) begin
      sel_q  <= 1'b0;
      dead_q <= 1'b0;
    end else begin
      if (flip_i) sel_q <= ~sel_q;
      dead_q <= flip_i;
    end
  end

  assign p1_o = en_i & ~sel_q & ~dead_q;
  assign p2_o = en_i &  sel_q & ~dead_q;

  // R6
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(p1_o && p2_o));
  // R6
  gap_after_p1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(p1_o) |-> !p2_o);
  // R6
  gap_after_p2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(p2_o) |-> !p1_o);
endmodule

// File: rtl/startup_cal_seq.sv
module startup_cal_seq
  import cal_seq_pkg::*;
#(
  parameter int GAIN_W = 8,
  parameter int TUNE_W = 8,
  parameter int DIV    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              tune_done_i,
  input  logic              tune_err_i,
  input  logic [TUNE_W-1:0] tune_code_i,
  input  logic              cmp_hit_i,
  output logic              tune_req_o,
  output logic              test_sw_en_o,
  output logic              conv_en_o,
  output logic              chop_p1_o,
  output logic              chop_p2_o,
  output logic [GAIN_W-1:0] gain_code_o,
  output logic [TUNE_W-1:0] tune_code_o,
  output logic [1:0]        phase_o,
  output logic              tune_fault_o,
  output logic              cal_err_o
);
  seq_st_e           st_q, st_d;
  logic [TUNE_W-1:0] tune_q;
  logic              in_cal, cal_tick, at_max, step;

  assign in_cal = (st_q == ST_CAL);
  assign step   = cal_tick & ~cmp_hit_i & ~at_max;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RST:  st_d = ST_TUNE;
      ST_TUNE: if (tune_done_i) st_d = tune_err_i ? ST_TFAIL : ST_CAL;
      ST_CAL:  if (cal_tick) begin
                 if (cmp_hit_i)   st_d = ST_RUN;
                 else if (at_max) st_d = ST_CFAIL;
               end
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RST;
      tune_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_TUNE && tune_done_i && !tune_err_i) tune_q <= tune_code_i;
    end
  end

  cal_tick_div #(.DIV(DIV)) i_div (
    .clk_i, .rst_ni, .en_i(in_cal), .slow_tick_i, .cal_tick_o(cal_tick)
  );

  gain_sweep #(.GAIN_W(GAIN_W)) i_sweep (
    .clk_i, .rst_ni, .clr_i(st_q == ST_TUNE), .step_i(step),
    .code_o(gain_code_o), .at_max_o(at_max)
  );

  chop_phase_gen i_chop (
    .clk_i, .rst_ni, .en_i(in_cal), .flip_i(cal_tick),
    .p1_o(chop_p1_o), .p2_o(chop_p2_o)
  );

  always_comb begin
    unique case (st_q)
      ST_TUNE: phase_o = PH_TUNE;
      ST_CAL:  phase_o = PH_CAL;
      ST_RUN:  phase_o = PH_RUN;
      default: phase_o = PH_IDLE;
    endcase
  end

  assign tune_req_o   = (st_q == ST_TUNE);
  assign test_sw_en_o = (st_q == ST_TUNE) | in_cal;
  assign conv_en_o    = (st_q == ST_RUN);
  assign tune_code_o  = tune_q;
  assign tune_fault_o = (st_q == ST_TFAIL);
  assign cal_err_o    = (st_q == ST_CFAIL);

  // R3
  tune_code_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_CAL || st_q == ST_RUN) && $past(st_q) != ST_TUNE) |-> $stable(tune_code_o));
  // R5
  run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_en_o |=> (conv_en_o && $stable(gain_code_o)));
  // R7
  cal_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_err_o |=> (cal_err_o && !conv_en_o));
  // R5
  run_only_from_cal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_en_o) |-> ($past(in_cal) && $past(cmp_hit_i)));
  // R4
  gain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_cal && $past(in_cal) && gain_code_o != $past(gain_code_o))
      |-> gain_code_o == $past(gain_code_o) + 1'b1);
endmodule

// File: tb/test_startup_cal_seq.sv
module test_startup_cal_seq;
  localparam int GW = 4, TW = 6, DIV = 8;
  localparam int GMAX = (1 << GW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0, slow_tick = 1'b0, tune_done = 1'b0, tune_err = 1'b0;
  logic [TW-1:0] tune_code_in = '0;
  logic          glitch = 1'b0;
  int            trip = 0;
  logic          cmp_hit;
  logic          tune_req, test_sw, conv_en, p1, p2, tfault, cerr;
  logic [GW-1:0] gain_code;
  logic [TW-1:0] tune_code;
  logic [1:0]    phase;

  assign cmp_hit = (int'(gain_code) >= trip) | glitch;

  startup_cal_seq #(.GAIN_W(GW), .TUNE_W(TW), .DIV(DIV)) i_startup_cal_seq (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow_tick), .tune_done_i(tune_done),
    .tune_err_i(tune_err), .tune_code_i(tune_code_in), .cmp_hit_i(cmp_hit),
    .tune_req_o(tune_req), .test_sw_en_o(test_sw), .conv_en_o(conv_en),
    .chop_p1_o(p1), .chop_p2_o(p2), .gain_code_o(gain_code), .tune_code_o(tune_code),
    .phase_o(phase), .tune_fault_o(tfault), .cal_err_o(cerr)
  );

  int  n_cmp = 0, n_bad = 0, cyc = 0;
  bit  done = 1'b0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; slow_tick = 1'b0; tune_done = 1'b0; tune_err = 1'b0; glitch = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 phase in reset", phase, 0);
    rst_n = 1'b1;
    #0;
    chk("R1 phase", phase, 0);
    chk("R1 conv_en", conv_en, 0);
    chk("R1 test_sw", test_sw, 0);
    chk("R1 tune_req", tune_req, 0);
    chk("R9 tune_fault cleared", tfault, 0);
    chk("R9 cal_err cleared", cerr, 0);
    @(negedge clk);
    chk("R2 phase", phase, 1);
    chk("R2 tune_req", tune_req, 1);
    chk("R2 test_sw", test_sw, 1);
    chk("R2 conv_en", conv_en, 0);
    chk("R2 gain zero", gain_code, 0);
  endtask

  task automatic slow_pulses(int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1'b1; @(negedge clk);
      slow_tick = 1'b0; glitch = 1'b1; @(negedge clk);
      glitch = 1'b0;
    end
  endtask

  task automatic run_case(int t, int tc);
    int ticks, calt, exp_ticks;
    trip = t;
    do_reset();
    tune_code_in = TW'(tc); tune_done = 1'b1;
    @(negedge clk);
    tune_done = 1'b0; tune_code_in = ~TW'(tc);
    chk("R3 phase", phase, 2);
    chk("R3 tune code captured", tune_code, tc);
    chk("R6 p1 first", p1, 1);
    chk("R6 p2 first", p2, 0);
    ticks = 0; calt = 0;
    while (phase == 2 && ticks < DIV * (GMAX + 3)) begin
      slow_tick = 1'b1; @(negedge clk);
      slow_tick = 1'b0; ticks++;
      if (ticks % DIV == 0) calt++;
      if (phase == 2 && ticks % DIV == 0) chk("R6 dead cycle", p1 | p2, 0);
      glitch = 1'b1; @(negedge clk);  // R10: comparator high off-tick
      glitch = 1'b0;
      if (phase == 2) begin
        chk("R6 p1", p1, (calt % 2 == 0) ? 1 : 0);
        chk("R6 p2", p2, (calt % 2 == 1) ? 1 : 0);
        chk("R4 gain per tick", gain_code, calt);
      end
    end
    if (t <= GMAX) begin
      exp_ticks = DIV * (t + 1);
      chk("R4 slow ticks to trip", ticks, exp_ticks);
      chk("R10 no early stop", gain_code, t);
      chk("R5 phase", phase, 3);
      chk("R5 conv_en", conv_en, 1);
      chk("R5 test_sw off", test_sw, 0);
      chk("R6 chop off", p1 | p2, 0);
      chk("R3 tune code held", tune_code, tc);
      trip = 0;
      slow_pulses(3 * DIV);
      chk("R5 gain held", gain_code, t);
      chk("R5 still run", phase, 3);
    end else begin
      chk("R7 slow ticks to fail", ticks, DIV * (GMAX + 1));
      chk("R7 cal_err", cerr, 1);
      chk("R7 phase", phase, 0);
      chk("R7 conv_en", conv_en, 0);
      chk("R7 test_sw", test_sw, 0);
      chk("R7 gain at max", gain_code, GMAX);
      trip = 0;
      slow_pulses(2 * DIV);
      chk("R7 sticky", cerr, 1);
      chk("R7 conv stays low", conv_en, 0);
    end
  endtask

  initial begin
    for (int t = 0; t <= GMAX + 1; t++) run_case(t, (t * 5 + 3) % 64);

    trip = 0;
    do_reset();
    tune_code_in = TW'(21); tune_done = 1'b1; tune_err = 1'b1;
    @(negedge clk);
    tune_done = 1'b0; tune_err = 1'b0;
    chk("R8 tune_fault", tfault, 1);
    chk("R8 phase", phase, 0);
    chk("R8 conv_en", conv_en, 0);
    chk("R8 test_sw", test_sw, 0);
    chk("R8 tune_req", tune_req, 0);
    chk("R8 code not loaded", tune_code, 0);
    slow_pulses(2 * DIV);
    chk("R8 stays faulted", phase, 0);
    chk("R8 flag sticky", tfault, 1);

    run_case(7, 40);  // R9: full sequence again after a fault

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule